// File: doc/BRIEF.md
# Two-Level Interrupt Context Save/Restore

This block holds the machine state that a processor core needs in order to leave an interrupt handler. Two classes of interrupt are served, noncritical and critical. Each class owns a pair of 32-bit save registers: one holds a return address and the other holds a copy of the machine-state register (MSR). When the core takes an interrupt it pulses an entry strobe with the class, the current program counter, the current MSR and a flag. The flag asks for the address of the following instruction to be saved instead of the current one. This is the case for a system call and for a watchdog-timer interrupt.

When a handler returns, the core pulses the return strobe for that class. In the same cycle the block presents the saved address as the next fetch address and the saved MSR as the value to reload. Every bit of the saved MSR is passed back, including bits the core treats as reserved. Software may inspect and modify all four registers through privileged move-to-SPR and move-from-SPR accesses. Entry, return and SPR accesses are single-cycle strobes with no back-pressure: the block accepts each strobe in the cycle it is raised. Critical interrupts are critical-input, machine-check, watchdog-timer and debug. The core decodes these and the block sees only the class bit.

Top module: `irq_ctx_save`

## Requirements
- R1: After reset all four save registers read as zero.
- R2: A noncritical entry (`irq_take`=1, `irq_crit`=0) loads save register 0 with the return address and save register 1 with `irq_msr` at the next clock edge. The return address is `irq_pc` when `irq_next`=0 and `irq_pc`+4 (modulo 2^32) when `irq_next`=1.
- R3: A critical entry (`irq_crit`=1) loads save registers 2 and 3 in the same way as R2 and leaves save registers 0 and 1 unchanged.
- R4: Bits [1:0] (little-endian numbering; the two lowest-order address bits) of save registers 0 and 2 are always zero, whether they were loaded by entry or by an SPR write.
- R5: When `ret_nc`=1 and `ret_crit`=0, `redir_valid` and `msr_load` are 1 in the same cycle, `redir_addr` equals save register 0 and `msr_value` equals save register 1.
- R6: When `ret_crit`=1, the outputs of R5 come from save registers 2 and 3, even if `ret_nc` is also 1. With neither strobe high, `redir_valid`, `msr_load`, `redir_addr` and `msr_value` are all 0.
- R7: The SPR addresses are 0x01A for save register 0, 0x01B for save register 1, and the parameters SPR_SAVE2 and SPR_SAVE3 (default 0x3DE and 0x3DF) for save registers 2 and 3. A privileged read returns the register in the same cycle. A privileged write takes effect at the next edge. Any other address reads 0 and raises no fault.
- R8: An SPR read or write to one of the four addresses with `spr_priv`=0 sets `priv_fault` in that cycle, reads 0 and changes no register.
- R9: If an entry and an SPR write to a register of the entering class fall in the same cycle, the entry value is stored. An SPR write to the other class's pair in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_take | input | 1 | Interrupt entry strobe |
| irq_crit | input | 1 | Entry class: 1 critical, 0 noncritical |
| irq_pc | input | 32 | Address of the current instruction |
| irq_msr | input | 32 | Current MSR |
| irq_next | input | 1 | Save the following instruction's address |
| ret_nc | input | 1 | Return from noncritical interrupt |
| ret_crit | input | 1 | Return from critical interrupt |
| redir_valid | output | 1 | Fetch redirection valid |
| redir_addr | output | 32 | Fetch redirection address |
| msr_load | output | 1 | Reload MSR strobe |
| msr_value | output | 32 | MSR value to reload |
| spr_rd | input | 1 | SPR read strobe |
| spr_wr | input | 1 | SPR write strobe |
| spr_addr | input | 10 | SPR number |
| spr_wdata | input | 32 | SPR write data |
| spr_priv | input | 1 | Accessor is in privileged mode |
| spr_rdata | output | 32 | SPR read data |
| priv_fault | output | 1 | Unprivileged access to a save register |

## Verification
The two functions that can fall in one cycle are interrupt entry and a software write to a save register. The bench raises `irq_take` and `spr_wr` in the same clock: once with the SPR write aimed at the MSR copy of the entering class, and once with it aimed at the other class's MSR copy. Afterwards it reads both registers back. The first must hold the captured MSR and the second must hold the written data. Separate checks cover a nested critical entry inside a noncritical handler and simultaneous return strobes.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int NUM_CLASSES    = 2;
  localparam int REGS_PER_CLASS = 2;
  localparam int NUM_REGS       = NUM_CLASSES * REGS_PER_CLASS;

  typedef enum logic {
    CLS_NONCRIT = 1'b0,
    CLS_CRIT    = 1'b1
  } irq_cls_e;
endpackage

// File: rtl/irq_ctx_pair.sv
module irq_ctx_pair #(
  parameter int DATA_W    = 32,
  parameter int ALIGN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_msr,
  input  logic              wr_addr_en,
  input  logic              wr_msr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] msr_q
);
  localparam logic [DATA_W-1:0] AMASK = ~((DATA_W'(1) << ALIGN_LSB) - DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      msr_q  <= '0;
    end else if (cap_en) begin
      addr_q <= cap_addr & AMASK;
      msr_q  <= cap_msr;
    end else begin
      if (wr_addr_en) addr_q <= wr_data & AMASK;
      if (wr_msr_en)  msr_q  <= wr_data;
    end
  end
endmodule

// File: rtl/irq_ctx_spr_dec.sv
module irq_ctx_spr_dec
  import irq_ctx_pkg::*;
#(
  parameter int SPR_AW = 10,
  parameter int A0 = 26,
  parameter int A1 = 27,
  parameter int A2 = 990,
  parameter int A3 = 991
) (
  input  logic [SPR_AW-1:0]   spr_addr,
  output logic [NUM_REGS-1:0] hit
);
  localparam logic [SPR_AW-1:0] MAP [NUM_REGS] =
    '{SPR_AW'(A0), SPR_AW'(A1), SPR_AW'(A2), SPR_AW'(A3)};

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) hit[k] = (spr_addr == MAP[k]);
  end
endmodule

// File: rtl/irq_ctx_save.sv
module irq_ctx_save
  import irq_ctx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SPR_AW     = 10,
  parameter int INSN_BYTES = 4,
  parameter int SPR_SAVE0  = 26,
  parameter int SPR_SAVE1  = 27,
  parameter int SPR_SAVE2  = 990,
  parameter int SPR_SAVE3  = 991
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic              irq_crit,
  input  logic [DATA_W-1:0] irq_pc,
  input  logic [DATA_W-1:0] irq_msr,
  input  logic              irq_next,
  input  logic              ret_nc,
  input  logic              ret_crit,
  output logic              redir_valid,
  output logic [DATA_W-1:0] redir_addr,
  output logic              msr_load,
  output logic [DATA_W-1:0] msr_value,
  input  logic              spr_rd,
  input  logic              spr_wr,
  input  logic [SPR_AW-1:0] spr_addr,
  input  logic [DATA_W-1:0] spr_wdata,
  input  logic              spr_priv,
  output logic [DATA_W-1:0] spr_rdata,
  output logic              priv_fault
);
  localparam int ALIGN_LSB = $clog2(INSN_BYTES);

  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wr_en;
  logic [DATA_W-1:0]   ret_addr;
  logic [DATA_W-1:0]   addr_q [NUM_CLASSES];
  logic [DATA_W-1:0]   msr_q  [NUM_CLASSES];
  irq_cls_e            ret_sel;

  // Observation points for the bound checker
  logic [DATA_W-1:0] s_addr_nc, s_msr_nc, s_addr_cr, s_msr_cr;

  irq_ctx_spr_dec #(
    .SPR_AW(SPR_AW), .A0(SPR_SAVE0), .A1(SPR_SAVE1), .A2(SPR_SAVE2), .A3(SPR_SAVE3)
  ) u_dec (
    .spr_addr(spr_addr),
    .hit     (hit)
  );

  assign priv_fault = (spr_rd | spr_wr) & (|hit) & ~spr_priv;
  assign wr_en      = (spr_wr && spr_priv) ? hit : '0;
  assign ret_addr   = irq_pc + (irq_next ? DATA_W'(INSN_BYTES) : '0);

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_pair
    irq_ctx_pair #(.DATA_W(DATA_W), .ALIGN_LSB(ALIGN_LSB)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (irq_take && (irq_crit == g[0])),
      .cap_addr  (ret_addr),
      .cap_msr   (irq_msr),
      .wr_addr_en(wr_en[g*REGS_PER_CLASS]),
      .wr_msr_en (wr_en[g*REGS_PER_CLASS+1]),
      .wr_data   (spr_wdata),
      .addr_q    (addr_q[g]),
      .msr_q     (msr_q[g])
    );
  end

  always_comb begin
    spr_rdata = '0;
    if (spr_rd && spr_priv) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (hit[k]) spr_rdata = (k % REGS_PER_CLASS == 1) ? msr_q[k / REGS_PER_CLASS]
                                                          : addr_q[k / REGS_PER_CLASS];
      end
    end
  end

  // Critical return has priority over a simultaneous noncritical one
  assign ret_sel     = ret_crit ? CLS_CRIT : CLS_NONCRIT;
  assign redir_valid = ret_nc | ret_crit;
  assign msr_load    = redir_valid;
  assign redir_addr  = redir_valid ? addr_q[ret_sel] : '0;
  assign msr_value   = redir_valid ? msr_q[ret_sel]  : '0;

  assign s_addr_nc = addr_q[CLS_NONCRIT];
  assign s_msr_nc  = msr_q[CLS_NONCRIT];
  assign s_addr_cr = addr_q[CLS_CRIT];
  assign s_msr_cr  = msr_q[CLS_CRIT];
endmodule

// File: rtl/irq_ctx_save_chk.sv
module irq_ctx_save_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_take,
  input logic        irq_crit,
  input logic [31:0] irq_pc,
  input logic [31:0] irq_msr,
  input logic        irq_next,
  input logic        ret_nc,
  input logic        ret_crit,
  input logic [31:0] redir_addr,
  input logic [31:0] msr_value,
  input logic        spr_wr,
  input logic        spr_priv,
  input logic [31:0] s_addr_nc,
  input logic [31:0] s_msr_nc,
  input logic [31:0] s_addr_cr,
  input logic [31:0] s_msr_cr
);
  // R2
  nc_msr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_crit) |=> (s_msr_nc == $past(irq_msr)));

  // R2
  nc_next_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_crit && irq_next) |=>
      (s_addr_nc == (($past(irq_pc) + 32'd4) & 32'hFFFF_FFFC)));

  // R3
  crit_keeps_nc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_crit && !spr_wr) |=> ($stable(s_addr_nc) && $stable(s_msr_nc)));

  // R5
  nc_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_nc && !ret_crit) |-> (redir_addr == s_addr_nc && msr_value == s_msr_nc));

  // R6
  crit_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_crit |-> (redir_addr == s_addr_cr && msr_value == s_msr_cr));

  // R8
  unpriv_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_wr && !spr_priv && !irq_take) |=>
      ($stable(s_addr_nc) && $stable(s_msr_nc) && $stable(s_addr_cr) && $stable(s_msr_cr)));
endmodule

bind irq_ctx_save irq_ctx_save_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_crit(irq_crit),
  .irq_pc(irq_pc), .irq_msr(irq_msr), .irq_next(irq_next),
  .ret_nc(ret_nc), .ret_crit(ret_crit), .redir_addr(redir_addr),
  .msr_value(msr_value), .spr_wr(spr_wr), .spr_priv(spr_priv),
  .s_addr_nc(s_addr_nc), .s_msr_nc(s_msr_nc),
  .s_addr_cr(s_addr_cr), .s_msr_cr(s_msr_cr)
);

// File: tb/irq_ctx_save_test.sv
`timescale 1ns/1ps
module irq_ctx_save_test;
  localparam logic [9:0] A0 = 10'h01A, A1 = 10'h01B, A2 = 10'h3DE, A3 = 10'h3DF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_take = 0, irq_crit = 0, irq_next = 0;
  logic [31:0] irq_pc = '0, irq_msr = '0;
  logic        ret_nc = 0, ret_crit = 0;
  logic        redir_valid, msr_load, priv_fault;
  logic [31:0] redir_addr, msr_value, spr_rdata;
  logic        spr_rd = 0, spr_wr = 0, spr_priv = 0;
  logic [9:0]  spr_addr = '0;
  logic [31:0] spr_wdata = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_ctx_save uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [9:0] a, logic priv, output logic [31:0] d, output logic f);
    @(negedge clk);
    spr_rd = 1; spr_addr = a; spr_priv = priv;
    #1;
    d = spr_rdata; f = priv_fault;
    spr_rd = 0; spr_priv = 0;
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d, logic priv, output logic f);
    @(negedge clk);
    spr_wr = 1; spr_addr = a; spr_wdata = d; spr_priv = priv;
    #1;
    f = priv_fault;
    @(negedge clk);
    spr_wr = 0; spr_priv = 0;
  endtask

  task automatic entry(logic crit, logic [31:0] pc, logic [31:0] msr, logic nxt);
    @(negedge clk);
    irq_take = 1; irq_crit = crit; irq_pc = pc; irq_msr = msr; irq_next = nxt;
    @(negedge clk);
    irq_take = 0;
  endtask

  task automatic expect_reg(string req, logic [9:0] a, logic [31:0] exp);
    logic [31:0] d; logic f;
    rd(a, 1'b1, d, f);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 save0", A0, 32'h0);
    expect_reg("R1 save1", A1, 32'h0);
    expect_reg("R1 save2", A2, 32'h0);
    expect_reg("R1 save3", A3, 32'h0);
  endtask

  task automatic t_entries;
    entry(1'b0, 32'h1000_0103, 32'hA5A5_0F0F, 1'b0);
    expect_reg("R2 addr (R4 aligned)", A0, 32'h1000_0100);
    expect_reg("R2 msr", A1, 32'hA5A5_0F0F);
    entry(1'b1, 32'h2000_0200, 32'h1234_5678, 1'b1);
    expect_reg("R3 addr next", A2, 32'h2000_0204);
    expect_reg("R3 msr", A3, 32'h1234_5678);
    expect_reg("R3 nc addr kept", A0, 32'h1000_0100);
    expect_reg("R3 nc msr kept", A1, 32'hA5A5_0F0F);
  endtask

  task automatic t_returns;
    @(negedge clk);
    #1;
    chk("R6 idle valid", {30'b0, redir_valid, msr_load}, 32'h0);
    chk("R6 idle addr", redir_addr, 32'h0);
    ret_nc = 1; #1;
    chk("R5 valid", {30'b0, redir_valid, msr_load}, 32'h3);
    chk("R5 addr", redir_addr, 32'h1000_0100);
    chk("R5 msr", msr_value, 32'hA5A5_0F0F);
    ret_nc = 0; ret_crit = 1; #1;
    chk("R6 addr", redir_addr, 32'h2000_0204);
    chk("R6 msr", msr_value, 32'h1234_5678);
    ret_nc = 1; #1;
    chk("R6 both strobes addr", redir_addr, 32'h2000_0204);
    ret_nc = 0; ret_crit = 0;
  endtask

  task automatic t_wrap;
    entry(1'b0, 32'hFFFF_FFFD, 32'h0000_0001, 1'b1);
    expect_reg("R2 wrap next addr", A0, 32'h0);
  endtask

  task automatic t_spr;
    logic f; logic [31:0] d;
    wr(A0, 32'hDEAD_BEEF, 1'b1, f);
    chk("R7 no fault priv", {31'b0, f}, 32'h0);
    expect_reg("R4 spr write aligned", A0, 32'hDEAD_BEEC);
    wr(A1, 32'hCAFE_F00D, 1'b1, f);
    expect_reg("R7 save1", A1, 32'hCAFE_F00D);
    wr(A2, 32'h0000_1237, 1'b1, f);
    expect_reg("R7 save2 (R4)", A2, 32'h0000_1234);
    wr(A3, 32'h5555_AAAA, 1'b1, f);
    expect_reg("R7 save3", A3, 32'h5555_AAAA);
    rd(10'h100, 1'b1, d, f);
    chk("R7 unmapped data", d, 32'h0);
    chk("R7 unmapped fault", {31'b0, f}, 32'h0);
  endtask

  task automatic t_priv;
    logic f; logic [31:0] d;
    wr(A1, 32'h0BAD_0BAD, 1'b0, f);
    chk("R8 write fault", {31'b0, f}, 32'h1);
    expect_reg("R8 save1 unchanged", A1, 32'hCAFE_F00D);
    wr(A2, 32'h0BAD_0BA0, 1'b0, f);
    expect_reg("R8 save2 unchanged", A2, 32'h0000_1234);
    rd(A3, 1'b0, d, f);
    chk("R8 read fault", {31'b0, f}, 32'h1);
    chk("R8 read data", d, 32'h0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    irq_take = 1; irq_crit = 0; irq_pc = 32'h3000_0008; irq_msr = 32'h0000_0011; irq_next = 0;
    spr_wr = 1; spr_priv = 1; spr_addr = A1; spr_wdata = 32'h0000_0099;
    @(negedge clk);
    irq_take = 0; spr_wr = 0; spr_priv = 0;
    expect_reg("R9 capture wins", A1, 32'h0000_0011);
    @(negedge clk);
    irq_take = 1; irq_crit = 0; irq_pc = 32'h3000_0010; irq_msr = 32'h0000_0022;
    spr_wr = 1; spr_priv = 1; spr_addr = A3; spr_wdata = 32'h0000_0077;
    @(negedge clk);
    irq_take = 0; spr_wr = 0; spr_priv = 0;
    expect_reg("R9 other pair write", A3, 32'h0000_0077);
    expect_reg("R9 nc msr captured", A1, 32'h0000_0022);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_entries();
    t_returns();
    t_wrap();
    t_spr();
    t_priv();
    t_collision();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule